// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Store-Trap Dirty Tracking

This block is a small, fully associative translation buffer. It maps a virtual page number to a physical frame number for every load or store presented on its request port. Each slot stores a valid flag, a frame number and a writable flag. The writable flag doubles as the page's modified marker. Offset bits pass through untouched. A request either completes with a translated physical address or ends in a trap, whose cause code tells trap-handling software what to do next.

The buffer never walks page tables. When no slot matches, it raises a miss trap that separates loads from stores. When a store lands on a slot whose writable flag is clear, it raises a write-protect trap, so the first write to a clean page becomes visible to software. Software then uses the fill port to install a translation. It installs it read-only after a load miss, or read-write after a store miss or a write-protect trap. A fill whose page number is already present rewrites that slot in place. A new page number goes into the slot chosen by a rotating pointer.

A separate invalidate port drops the slot holding a given page number. A flush strobe empties the whole buffer in one cycle, so no stale copy outlives a page-table change.

Top module: `xlat_buf`

## Requirements
- R1: After reset no slot is valid and rspValid is 0, so every lookup made before the first fill traps as a miss.
- R2: Each cycle with reqValid high gives exactly one response, one clock later. rspValid is high in that cycle only, and rspValid stays low after a cycle with no request.
- R3: A load (reqStore=0) whose page number matches no valid slot returns rspHit=0, rspTrap=1, rspCause=1 and rspPaddr=0.
- R4: A store (reqStore=1) whose page number matches no valid slot returns rspHit=0, rspTrap=1, rspCause=2 and rspPaddr=0.
- R5: A store that matches a valid slot whose writable flag is 0 returns rspHit=0, rspTrap=1, rspCause=3 and rspPaddr=0.
- R6: A load that matches any valid slot, or a store that matches a writable slot, returns rspHit=1, rspTrap=0 and rspCause=0. rspPaddr is then the slot's frame number in bits 31:12 and request address bits 11:0 in bits 11:0. The page number is request address bits 31:12.
- R7: A fill installs its frame number with the writable flag set to fillWritable (0 read-only, 1 read-write). A fill whose page number already sits in a valid slot overwrites that slot, so it never creates a second copy and never evicts another slot.
- R8: A fill with a new page number writes the slot selected by a rotating pointer. The pointer starts at slot 0 and advances by one, modulo 8, only on such fills. Nine distinct fills after reset therefore evict the first one.
- R9: An invalidate removes only the valid slot holding invVpn. Other slots keep translating.
- R10: A flushAll strobe clears every slot in one cycle.
- R11: flushAll takes precedence over invValid, and invValid takes precedence over a fill. A fill in a cycle with flushAll or invValid high is dropped.
- R12: A lookup made in the same cycle as a fill, invalidate or flush sees the slot contents as they were before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Lookup request strobe |
| reqStore | input | 1 | 1 for a store, 0 for a load |
| reqVaddr | input | 32 | Virtual address (page number in 31:12, offset in 11:0) |
| fillValid | input | 1 | Install or rewrite one translation |
| fillVpn | input | 20 | Page number to install |
| fillPfn | input | 20 | Frame number to install |
| fillWritable | input | 1 | 1 installs read-write (modified), 0 read-only |
| invValid | input | 1 | Remove the slot holding invVpn |
| invVpn | input | 20 | Page number to remove |
| flushAll | input | 1 | Clear every slot |
| rspValid | output | 1 | Response strobe, one cycle after a request |
| rspHit | output | 1 | Translation succeeded |
| rspPaddr | output | 32 | Physical address on a hit, zero otherwise |
| rspTrap | output | 1 | Request trapped |
| rspCause | output | 2 | 0 none, 1 load miss, 2 store miss, 3 write-protect |

## Verification
The assertion that at most one slot matches a lookup relies on every install going through the fill port, which rewrites a matching slot instead of adding a copy. The stimulus therefore never loads the buffer any other way, and it reuses a small set of page numbers so that overwrites happen often. The response-timing assertions take reqValid to be a clean one-cycle strobe sampled at the clock edge. The bench drives all inputs on the falling edge. It also mixes fills, invalidates and flushes into the same cycles as lookups, so that the priority and same-cycle visibility rules are exercised.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_LD_MISS = 2'd1,
    CAUSE_ST_MISS = 2'd2,
    CAUSE_WR_PROT = 2'd3
  } trapCause_t;

  // strobes from control to the slot array
  typedef struct packed {
    logic clearAll;
    logic clearOne;
    logic writeEn;
    logic writeWr;
  } slotCmd_t;

endpackage

// File: rtl/xlat_slots.sv
module xlat_slots
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  slotCmd_t           cmd,
  input  logic [IDX_W-1:0]   writeIdx,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [VPN_W-1:0]   flVpn,
  input  logic [PFN_W-1:0]   flPfn,
  input  logic [VPN_W-1:0]   ivVpn,
  output logic [ENTRIES-1:0] flMatch,
  output logic               lkHit,
  output logic               lkWritable,
  output logic [PFN_W-1:0]   lkPfn
);

  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] writableQ;
  logic [VPN_W-1:0]   vpnQ [ENTRIES];
  logic [PFN_W-1:0]   pfnQ [ENTRIES];

  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] ivMatch;

  // parallel tag compare, one comparator set per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign lkMatch[g] = validQ[g] && (vpnQ[g] == lkVpn);
    assign flMatch[g] = validQ[g] && (vpnQ[g] == flVpn);
    assign ivMatch[g] = validQ[g] && (vpnQ[g] == ivVpn);
  end

  always_comb begin
    lkPfn      = '0;
    lkWritable = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkMatch[i]) begin
        lkPfn      = lkPfn | pfnQ[i];
        lkWritable = lkWritable | writableQ[i];
      end
    end
  end

  assign lkHit = |lkMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ    <= '0;
      writableQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i] <= '0;
        pfnQ[i] <= '0;
      end
    end else if (cmd.clearAll) begin
      validQ <= '0;
    end else if (cmd.clearOne) begin
      validQ <= validQ & ~ivMatch;
    end else if (cmd.writeEn) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (writeIdx == IDX_W'(i)) begin
          validQ[i]    <= 1'b1;
          writableQ[i] <= cmd.writeWr;
          vpnQ[i]      <= flVpn;
          pfnQ[i]      <= flPfn;
        end
      end
    end
  end

  // R7: fills rewrite a matching slot, so a lookup never sees two copies
  a_r7_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatch));

  // R10: a flush leaves nothing valid
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearAll |=> (validQ == '0));

  // R9: an invalidate never adds a valid slot
  a_r9_inv_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearOne |=> ($countones(validQ) <= $countones($past(validQ))));

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqStore,
  input  logic [OFF_W-1:0]   reqOff,
  input  logic               fillValid,
  input  logic               fillWritable,
  input  logic               invValid,
  input  logic               flushAll,
  input  logic [ENTRIES-1:0] flMatch,
  input  logic               lkHit,
  input  logic               lkWritable,
  input  logic [PFN_W-1:0]   lkPfn,
  output slotCmd_t           cmd,
  output logic [IDX_W-1:0]   writeIdx,
  output logic               rspValid,
  output logic               rspHit,
  output logic [PA_W-1:0]    rspPaddr,
  output logic               rspTrap,
  output logic [1:0]         rspCause
);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] fillSlot;
  logic             flHitAny;
  trapCause_t       causeNext;
  trapCause_t       causeQ;

  // update priority: flush, then invalidate, then fill
  always_comb begin
    cmd.clearAll = flushAll;
    cmd.clearOne = invValid && !flushAll;
    cmd.writeEn  = fillValid && !flushAll && !invValid;
    cmd.writeWr  = fillWritable;
  end

  always_comb begin
    fillSlot = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (flMatch[i]) fillSlot = IDX_W'(i);
    end
  end

  assign flHitAny = |flMatch;
  assign writeIdx = flHitAny ? fillSlot : rrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (cmd.writeEn && !flHitAny) begin
      if (rrPtr == IDX_W'(ENTRIES - 1)) rrPtr <= '0;
      else                              rrPtr <= rrPtr + 1'b1;
    end
  end

  always_comb begin
    if (!lkHit)                     causeNext = reqStore ? CAUSE_ST_MISS : CAUSE_LD_MISS;
    else if (reqStore && !lkWritable) causeNext = CAUSE_WR_PROT;
    else                            causeNext = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspTrap  <= 1'b0;
      rspPaddr <= '0;
      causeQ   <= CAUSE_NONE;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        causeQ   <= causeNext;
        rspTrap  <= (causeNext != CAUSE_NONE);
        rspHit   <= (causeNext == CAUSE_NONE);
        rspPaddr <= (causeNext == CAUSE_NONE) ? {lkPfn, reqOff} : '0;
      end else begin
        causeQ   <= CAUSE_NONE;
        rspTrap  <= 1'b0;
        rspHit   <= 1'b0;
        rspPaddr <= '0;
      end
    end
  end

  assign rspCause = causeQ;

  // R2: one response per request, one clock later
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R5: write-protect only ever answers a store
  a_r5_wprot_from_store: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCause == 2'd3) |-> $past(reqStore));

  // R3: a miss on a load reports the load-miss code
  a_r3_ld_miss_code: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqStore && !lkHit) |=> (rspTrap && rspCause == 2'd1));

  // R8: the pointer moves on every fill of a new page number
  a_r8_rr_moves: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.writeEn && !flHitAny) |=> (rrPtr != $past(rrPtr)));

endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqStore,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic             fillWritable,
  input  logic             invValid,
  input  logic [VPN_W-1:0] invVpn,
  input  logic             flushAll,
  output logic             rspValid,
  output logic             rspHit,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             rspTrap,
  output logic [1:0]       rspCause
);

  slotCmd_t           cmd;
  logic [IDX_W-1:0]   writeIdx;
  logic [ENTRIES-1:0] flMatch;
  logic               lkHit;
  logic               lkWritable;
  logic [PFN_W-1:0]   lkPfn;

  xlat_slots #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_slots (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .writeIdx  (writeIdx),
    .lkVpn     (reqVaddr[OFF_W +: VPN_W]),
    .flVpn     (fillVpn),
    .flPfn     (fillPfn),
    .ivVpn     (invVpn),
    .flMatch   (flMatch),
    .lkHit     (lkHit),
    .lkWritable(lkWritable),
    .lkPfn     (lkPfn)
  );

  xlat_ctrl #(
    .ENTRIES(ENTRIES), .PFN_W(PFN_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqStore    (reqStore),
    .reqOff      (reqVaddr[OFF_W-1:0]),
    .fillValid   (fillValid),
    .fillWritable(fillWritable),
    .invValid    (invValid),
    .flushAll    (flushAll),
    .flMatch     (flMatch),
    .lkHit       (lkHit),
    .lkWritable  (lkWritable),
    .lkPfn       (lkPfn),
    .cmd         (cmd),
    .writeIdx    (writeIdx),
    .rspValid    (rspValid),
    .rspHit      (rspHit),
    .rspPaddr    (rspPaddr),
    .rspTrap     (rspTrap),
    .rspCause    (rspCause)
  );

endmodule

// File: tb/xlat_buf_bench.sv
`timescale 1ns/1ps
module xlat_buf_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0, reqStore = 0;
  logic [31:0] reqVaddr = '0;
  logic        fillValid = 0, fillWritable = 0;
  logic [19:0] fillVpn = '0, fillPfn = '0;
  logic        invValid = 0, flushAll = 0;
  logic [19:0] invVpn = '0;
  logic        rspValid, rspHit, rspTrap;
  logic [31:0] rspPaddr;
  logic [1:0]  rspCause;

  always #5 clk = ~clk;

  xlat_buf u_xlat_buf (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqStore(reqStore), .reqVaddr(reqVaddr),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillWritable(fillWritable),
    .invValid(invValid), .invVpn(invVpn), .flushAll(flushAll),
    .rspValid(rspValid), .rspHit(rspHit), .rspPaddr(rspPaddr),
    .rspTrap(rspTrap), .rspCause(rspCause)
  );

  int    checks = 0;
  int    failures = 0;
  bit    started = 0;
  bit    finished = 0;
  string curTag = "R2";

  // behavioural reference: an 8-slot table with a rotating victim counter
  bit      mValid [8];
  bit      mWr    [8];
  int      mVpn   [8];
  int      mPfn   [8];
  int      mRr = 0;
  bit      expValid = 0, expHit = 0, expTrap = 0;
  int      expCause = 0;
  longint  expPaddr = 0;
  string   expTag = "R2";

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin mValid[i] = 0; mWr[i] = 0; end
      mRr = 0; expValid = 0;
    end else begin
      int k;
      expValid = reqValid; expTag = curTag;
      expHit = 0; expTrap = 0; expCause = 0; expPaddr = 0;
      if (reqValid) begin
        k = -1;
        for (int i = 0; i < 8; i++)
          if (mValid[i] && mVpn[i] == int'(reqVaddr[31:12])) k = i;
        if (k < 0) begin
          expTrap = 1; expCause = reqStore ? 2 : 1;
        end else if (reqStore && !mWr[k]) begin
          expTrap = 1; expCause = 3;
        end else begin
          expHit = 1;
          expPaddr = longint'(mPfn[k]) * 4096 + longint'(reqVaddr[11:0]);
        end
      end
      if (flushAll) begin
        for (int i = 0; i < 8; i++) mValid[i] = 0;
      end else if (invValid) begin
        for (int i = 0; i < 8; i++)
          if (mValid[i] && mVpn[i] == int'(invVpn)) mValid[i] = 0;
      end else if (fillValid) begin
        k = -1;
        for (int i = 0; i < 8; i++)
          if (mValid[i] && mVpn[i] == int'(fillVpn)) k = i;
        if (k < 0) begin k = mRr; mRr = (mRr + 1) % 8; end
        mValid[k] = 1; mWr[k] = fillWritable;
        mVpn[k] = int'(fillVpn); mPfn[k] = int'(fillPfn);
      end
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (rspValid !== expValid) begin
        failures++;
        $display("FAIL R2 (%s) rspValid actual=%0b expected=%0b", expTag, rspValid, expValid);
      end else if (expValid) begin
        if (rspHit !== expHit || rspTrap !== expTrap ||
            int'(rspCause) != expCause || longint'(rspPaddr) != expPaddr) begin
          failures++;
          $display("FAIL %s hit/trap/cause/paddr actual=%0b/%0b/%0d/%h expected=%0b/%0b/%0d/%h",
                   expTag, rspHit, rspTrap, rspCause, rspPaddr,
                   expHit, expTrap, expCause, expPaddr[31:0]);
        end
      end
    end
  end

  task automatic cyc(input bit rv, input bit rs, input logic [31:0] va,
                     input bit fv, input logic [19:0] fvpn, input logic [19:0] fpfn,
                     input bit fw, input bit iv, input logic [19:0] ivpn,
                     input bit fa, input string tag);
    reqValid = rv; reqStore = rs; reqVaddr = va;
    fillValid = fv; fillVpn = fvpn; fillPfn = fpfn; fillWritable = fw;
    invValid = iv; invVpn = ivpn; flushAll = fa; curTag = tag;
    @(negedge clk);
  endtask

  task automatic ld(input logic [31:0] va, input string tag);
    cyc(1, 0, va, 0, '0, '0, 0, 0, '0, 0, tag);
  endtask
  task automatic st(input logic [31:0] va, input string tag);
    cyc(1, 1, va, 0, '0, '0, 0, 0, '0, 0, tag);
  endtask
  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input bit w, input string tag);
    cyc(0, 0, '0, 1, vpn, pfn, w, 0, '0, 0, tag);
  endtask
  task automatic inv(input logic [19:0] vpn, input string tag);
    cyc(0, 0, '0, 0, '0, '0, 0, 1, vpn, 0, tag);
  endtask
  task automatic flush(input string tag);
    cyc(0, 0, '0, 0, '0, '0, 0, 0, '0, 1, tag);
  endtask
  task automatic idle();
    cyc(0, 0, '0, 0, '0, '0, 0, 0, '0, 0, "R2");
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (rspValid !== 1'b0) begin
      failures++;
      $display("FAIL R1 rspValid during reset actual=%0b expected=0", rspValid);
    end
    rstN = 1'b1;
    @(negedge clk);
    started = 1;

    // R1, R3, R4: empty buffer misses
    ld(32'h0001_2345, "R1");
    ld(32'hABCD_E000, "R3");
    st(32'hABCD_E004, "R4");
    idle();

    // R7, R5, R6: read-only install, store trap, upgrade to read-write
    fill(20'h00012, 20'h7_7777, 0, "R7");
    ld(32'h0001_2ABC, "R6");
    st(32'h0001_2ABC, "R5");
    fill(20'h00012, 20'h7_7777, 1, "R7");
    st(32'h0001_2FFF, "R6");
    fill(20'h00012, 20'h3_1000, 1, "R7");
    ld(32'h0001_2001, "R7");

    // R8: nine distinct fills evict the oldest
    flush("R10");
    for (int i = 0; i < 9; i++) fill(20'h40000 + 20'(i), 20'h10000 + 20'(i), i[0], "R8");
    for (int i = 0; i < 9; i++) ld({20'h40000 + 20'(i), 12'h055}, "R8");
    for (int i = 1; i < 9; i++) st({20'h40000 + 20'(i), 12'h0A0}, "R8");

    // R9: invalidate one page only
    inv(20'h40003, "R9");
    ld({20'h40003, 12'h000}, "R9");
    ld({20'h40004, 12'h000}, "R9");

    // R12: lookup alongside an invalidate sees the old contents
    cyc(1, 0, {20'h40004, 12'h111}, 0, '0, '0, 0, 1, 20'h40004, 0, "R12");
    ld({20'h40004, 12'h111}, "R12");
    cyc(1, 0, {20'h55555, 12'h0}, 1, 20'h55555, 20'hAAAAA, 1, 0, '0, 0, "R12");
    ld({20'h55555, 12'h0}, "R12");

    // R11: update priority
    cyc(0, 0, '0, 1, 20'h66666, 20'h1, 1, 0, '0, 1, "R11");
    ld({20'h66666, 12'h0}, "R11");
    ld({20'h55555, 12'h0}, "R10");
    fill(20'h77777, 20'h2, 1, "R11");
    cyc(0, 0, '0, 1, 20'h66666, 20'h3, 1, 1, 20'h77777, 0, "R11");
    ld({20'h66666, 12'h0}, "R11");
    ld({20'h77777, 12'h0}, "R11");

    // mixed traffic over a small page set
    for (int n = 0; n < 4000; n++) begin
      int r;
      bit rv, rs, fv, fw, iv, fa;
      logic [19:0] pv, fp, iw;
      r  = int'($urandom_range(0, 99));
      rv = ($urandom_range(0, 9) < 7);
      rs = $urandom_range(0, 1) == 1;
      pv = 20'h80000 + 20'($urandom_range(0, 11));
      fv = (r < 30);
      fp = 20'($urandom);
      fw = $urandom_range(0, 1) == 1;
      iv = (r >= 30 && r < 35);
      iw = 20'h80000 + 20'($urandom_range(0, 11));
      fa = (r == 99);
      cyc(rv, rs, {pv, 12'($urandom)}, fv, 20'h80000 + 20'($urandom_range(0, 11)),
          fp, fw, iv, iw, fa, "R6");
    end
    idle();
    idle();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule